// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block watches a pair of redundant cores that run the same program, one of them trailing the other by a fixed number of clock cycles (two by default). Each cycle both cores present an output bundle. The leading core's bundle is pushed through a short register pipeline so that it lines up in time with the trailing core's bundle. The two aligned bundles are then compared bit for bit.

The first difference found sets a sticky alarm. The block also stores the value of a free-running cycle counter for that cycle, which gives the time of the first divergence. Only an explicit clear input or reset removes the alarm. An enable input turns checking on and off. Whenever checking starts, whether after reset or after the enable has been low, the first LAG cycles are not compared, because the pipeline does not yet hold a matching leading-core bundle.

Both bundles are sampled every clock with no valid/ready handshake. Lockstep cores cannot be stalled independently, so the comparator never applies back-pressure and has no way to accept a bundle late.

Top module: `lockstep_cmp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `alarm` is 0 and `fail_cycle` is 0.
- R2: If `chk_bus` in cycle n equals `mst_bus` from cycle n-LAG (LAG defaults to 2), `alarm` stays 0.
- R3: While comparison is live, `alarm` is 1 in the cycle after the one in which `chk_bus` differs from `mst_bus` of LAG cycles earlier. A difference in a single bit sets it, at any bit position from 0 to BUNDLE_W-1.
- R4: The first LAG cycles with `en` high are never compared. This applies after reset is released and after every cycle in which `en` was low. A difference in cycle LAG+1 of an enabled run is detected.
- R5: A difference in a cycle with `en` low does not set `alarm`.
- R6: Once set, `alarm` stays 1 until `clr` is high at a clock edge, whatever the inputs do.
- R7: `fail_cycle` holds the cycle count of the cycle whose difference set `alarm`. Cycle counting starts at 0 in the first cycle after reset release and goes up by one per clock. Later differences leave it unchanged while `alarm` is 1.
- R8: `clr` high at an edge makes `alarm` 0 and `fail_cycle` 0 after that edge. It takes priority over a difference in the same cycle.
- R9: After a clear, a new difference sets `alarm` again and records its own cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with both cores |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Checking enable; low stops comparison and restarts the warm-up |
| clr | input | 1 | Clears the alarm and the recorded cycle |
| mst_bus | input | BUNDLE_W | Output bundle of the leading core |
| chk_bus | input | BUNDLE_W | Output bundle of the trailing core |
| alarm | output | 1 | Sticky divergence flag |
| fail_cycle | output | CNT_W | Cycle count at which the first divergence was seen |

## Verification
The properties assume that `en`, `clr` and `rst_n` are known, synchronous levels, and that the trailing bundle is judged against the leading bundle exactly LAG cycles older. They use the block's own aligned copy of the leading bundle as the reference. The bench drives every input only at the falling clock edge. It builds the trailing stream from its own two-deep copy of the random leading stream, and it introduces differences only through an explicit XOR mask. The enable is dropped only as a whole-cycle level, so the warm-up rule always applies to complete cycles.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int unsigned LSC_LAG_DEF  = 2;
  localparam int unsigned LSC_LANE_DEF = 8;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_FILL = 2'd1,
    PH_LIVE = 2'd2
  } lsc_phase_e;

endpackage

// File: rtl/lsc_delay.sv
// Aligns the leading core's bundle with the trailing core's bundle.
// The data path has no reset: the gate masks comparison until the
// pipeline has been refilled.
module lsc_delay #(
  parameter int unsigned W   = 64,
  parameter int unsigned LAG = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [LAG-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    stg_q[0] <= din;
    for (int s = 1; s < LAG; s++) begin
      stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[LAG-1];

endmodule

// File: rtl/lsc_gate.sv
// Tracks how many consecutive enabled cycles have filled the pipeline.
module lsc_gate
  import lsc_pkg::*;
#(
  parameter int unsigned LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic live
);

  localparam int unsigned CW = $clog2(LAG + 1);
  localparam logic [CW-1:0] FULL = CW'(LAG);

  logic [CW-1:0] fill_q;
  lsc_phase_e    phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fill_q <= '0;
    else if (!en)            fill_q <= '0;
    else if (fill_q != FULL) fill_q <= fill_q + CW'(1);
  end

  always_comb begin
    if (!en)                 phase = PH_OFF;
    else if (fill_q != FULL) phase = PH_FILL;
    else                     phase = PH_LIVE;
  end

  assign live = (phase == PH_LIVE);

endmodule

// File: rtl/lsc_diff.sv
// Lane-split inequality: each lane reduces its XOR, then the lanes are ORed.
module lsc_diff #(
  parameter int unsigned W      = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         ne
);

  localparam int unsigned NLANE = (W + LANE_W - 1) / LANE_W;
  localparam int unsigned PW    = NLANE * LANE_W;

  logic [PW-1:0]    x;
  logic [NLANE-1:0] lane_ne;

  assign x = PW'(a ^ b);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign lane_ne[i] = |x[i*LANE_W +: LANE_W];
  end

  assign ne = |lane_ne;

endmodule

// File: rtl/lsc_capture.sv
// Cycle counter plus sticky alarm with first-hit time stamp.
module lsc_capture #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic             alarm,
  output logic [CNT_W-1:0] fail_cycle
);

  logic [CNT_W-1:0] cyc_q;
  logic             alarm_q;
  logic [CNT_W-1:0] stamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      stamp_q <= '0;
    end else if (clr) begin
      alarm_q <= 1'b0;
      stamp_q <= '0;
    end else if (hit && !alarm_q) begin
      alarm_q <= 1'b1;
      stamp_q <= cyc_q;
    end
  end

  assign alarm      = alarm_q;
  assign fail_cycle = stamp_q;

endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lsc_pkg::*;
#(
  parameter int unsigned BUNDLE_W = 64,
  parameter int unsigned LAG      = LSC_LAG_DEF,
  parameter int unsigned LANE_W   = LSC_LANE_DEF,
  parameter int unsigned CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                clr,
  input  logic [BUNDLE_W-1:0] mst_bus,
  input  logic [BUNDLE_W-1:0] chk_bus,
  output logic                alarm,
  output logic [CNT_W-1:0]    fail_cycle
);

  logic [BUNDLE_W-1:0] mst_aligned;
  logic                live;
  logic                differ;
  logic                hit;

  lsc_delay #(.W(BUNDLE_W), .LAG(LAG)) u_delay (
    .clk  (clk),
    .din  (mst_bus),
    .dout (mst_aligned)
  );

  lsc_gate #(.LAG(LAG)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .live  (live)
  );

  lsc_diff #(.W(BUNDLE_W), .LANE_W(LANE_W)) u_diff (
    .a  (mst_aligned),
    .b  (chk_bus),
    .ne (differ)
  );

  assign hit = live & differ;

  lsc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .hit        (hit),
    .alarm      (alarm),
    .fail_cycle (fail_cycle)
  );

endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
  parameter int unsigned W     = 64,
  parameter int unsigned LAG   = 2,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             clr,
  input logic [W-1:0]     chk_bus,
  input logic [W-1:0]     aligned,
  input logic             alarm,
  input logic [CNT_W-1:0] fail_cycle
);

  localparam int unsigned CW = $clog2(LAG + 1);
  localparam logic [CW-1:0] FULL = CW'(LAG);

  // Count of consecutive enabled cycles, saturating at LAG
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (!en)           run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + CW'(1);
  end

  a_r1_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (alarm == 1'b0 && fail_cycle == '0));

  a_r3_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q == FULL && chk_bus != aligned && !clr) |=> alarm);

  a_r4_warmup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != FULL && !alarm) |=> !alarm);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !alarm) |=> !alarm);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> alarm);

  a_r7_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> $stable(fail_cycle));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!alarm && fail_cycle == '0));

endmodule

bind lockstep_cmp lsc_chk #(.W(BUNDLE_W), .LAG(LAG), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .clr        (clr),
  .chk_bus    (chk_bus),
  .aligned    (mst_aligned),
  .alarm      (alarm),
  .fail_cycle (fail_cycle)
);

// File: tb/lockstep_cmp_test.sv
module lockstep_cmp_test;

  localparam int CLK_P = 10;
  localparam int W     = 64;
  localparam int CW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          clr = 1'b0;
  logic [W-1:0]  mst_bus = '0;
  logic [W-1:0]  chk_bus = '0;
  logic          alarm;
  logic [CW-1:0] fail_cycle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  logic [W-1:0]  h0 = '0, h1 = '0;
  int            mfill = 0;
  logic          malarm = 1'b0;
  logic [CW-1:0] mfail = '0;
  logic [CW-1:0] mcyc = '0;

  always #(CLK_P/2) clk = ~clk;

  lockstep_cmp uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .clr        (clr),
    .mst_bus    (mst_bus),
    .chk_bus    (chk_bus),
    .alarm      (alarm),
    .fail_cycle (fail_cycle)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] bit_at(input int p);
    return W'(1) << p;
  endfunction

  // One cycle: inputs driven at a falling edge, outputs checked at the next
  task automatic step(input logic e, input logic c, input logic [W-1:0] flip,
                      input string tag);
    logic [W-1:0] m;
    logic         act;
    logic         ne;
    m = {$urandom, $urandom};
    en = e; clr = c; mst_bus = m; chk_bus = h1 ^ flip;
    @(posedge clk);
    act = e && (mfill == 2);
    ne  = act && (chk_bus != h1);
    if (c) begin
      malarm = 1'b0; mfail = '0;
    end else if (ne && !malarm) begin
      malarm = 1'b1; mfail = mcyc;
    end
    mfill = e ? ((mfill < 2) ? mfill + 1 : 2) : 0;
    h1 = h0; h0 = m; mcyc = mcyc + 1;
    @(negedge clk);
    check(tag, "alarm", 64'(alarm), 64'(malarm));
    check(tag, "fail_cycle", 64'(fail_cycle), 64'(mfail));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1; clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "alarm in reset", 64'(alarm), 64'd0);
    check("R1", "fail_cycle in reset", 64'(fail_cycle), 64'd0);
    malarm = 1'b0; mfail = '0; mcyc = '0; mfill = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] n;
    logic [CW-1:0] first;
    void'($urandom(32'd4711));

    do_reset();
    check("R1", "alarm after release", 64'(alarm), 64'd0);

    // R4: both warm-up cycles carry a full-width difference
    step(1, 0, '1, "R4 warm-up");
    step(1, 0, '1, "R4 warm-up");
    check("R4", "alarm after warm-up", 64'(alarm), 64'd0);

    // R2: aligned matching streams
    repeat (40) step(1, 0, '0, "R2 matched");
    check("R2", "alarm on matched streams", 64'(alarm), 64'd0);

    // R3 + R7: single low-bit difference
    n = mcyc;
    step(1, 0, bit_at(0), "R3 bit0");
    check("R3", "alarm bit0", 64'(alarm), 64'd1);
    check("R7", "fail_cycle first", 64'(fail_cycle), 64'(n));
    first = n;

    // R7: later differences do not move the stamp
    step(1, 0, bit_at(W-1), "R7 later diff");
    check("R7", "fail_cycle held", 64'(fail_cycle), 64'(first));

    // R6: alarm holds through clean traffic and through enable low
    repeat (6) step(1, 0, '0, "R6 hold");
    repeat (4) step(0, 0, '0, "R6 hold en low");
    check("R6", "alarm sticky", 64'(alarm), 64'd1);
    repeat (3) step(1, 0, '0, "R6 refill");

    // R8: clear wins over a same-cycle difference
    step(1, 1, '1, "R8 clear");
    check("R8", "alarm cleared", 64'(alarm), 64'd0);
    check("R8", "fail_cycle cleared", 64'(fail_cycle), 64'd0);
    step(1, 1, bit_at(17), "R8 clear vs diff");
    check("R8", "alarm clear priority", 64'(alarm), 64'd0);

    // R9 + R3: re-arm, top bit
    repeat (5) step(1, 0, '0, "R2 matched");
    n = mcyc;
    step(1, 0, bit_at(W-1), "R9 rearm");
    check("R9", "alarm rearmed", 64'(alarm), 64'd1);
    check("R9", "fail_cycle new", 64'(fail_cycle), 64'(n));
    step(1, 1, '0, "R8 clear");

    // R5: disabled differences are ignored
    repeat (6) step(0, 0, '1, "R5 disabled");
    check("R5", "alarm while disabled", 64'(alarm), 64'd0);

    // R4: enable restarts warm-up; cycle LAG+1 is compared
    step(1, 0, '1, "R4 re-enable");
    step(1, 0, '1, "R4 re-enable");
    check("R4", "alarm in re-enable warm-up", 64'(alarm), 64'd0);
    n = mcyc;
    step(1, 0, bit_at(5), "R4 first live");
    check("R4", "alarm at first live cycle", 64'(alarm), 64'd1);
    check("R7", "fail_cycle first live", 64'(fail_cycle), 64'(n));
    step(1, 1, '0, "R8 clear");

    // Random traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      logic          e;
      logic          c;
      logic [W-1:0]  f;
      e = ($urandom % 20) != 0;
      c = ($urandom % 60) == 0;
      f = (($urandom % 40) == 0) ? bit_at(int'($urandom % W)) : '0;
      step(e, c, f, "R3 R6 R7 random");
    end

    // R1: reset while the alarm is set
    repeat (3) step(1, 0, '0, "R2 matched");
    step(1, 0, '1, "R3 before reset");
    check("R3", "alarm before reset", 64'(alarm), 64'd1);
    do_reset();
    check("R1", "alarm after mid-run reset", 64'(alarm), 64'd0);
    check("R1", "fail_cycle after mid-run reset", 64'(fail_cycle), 64'd0);
    step(1, 0, '1, "R4 warm-up after reset");
    step(1, 0, '1, "R4 warm-up after reset");
    repeat (5) step(1, 0, '0, "R2 matched");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule